// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block is a memory-mapped general-purpose I/O controller. It is split into several banks of up to 32 pins each. Each bank has its own set of registers: output value, pin direction, open-drain select, three trigger-configuration words, an interrupt mask and a sticky interrupt status. The registers sit on a simple 32-bit bus with one access per cycle. Writes take effect on the clock edge. A read returns its data one cycle after the address is presented.

Pin inputs pass through a two-flop synchronizer. Each pin can then raise its status bit on a rising edge, a falling edge, either edge, a high level or a low level. Status bits latch whether or not they are masked, and software clears them by writing ones. Any status bit whose mask bit is also set raises one combined interrupt for all banks. A second, wake output is driven from the same masked status so that it can be routed to an always-on controller.

A bank whose configured width is zero still takes up its eight-word slot, but all of its registers read as zero.

Top module: `gpio_mb_top`

## Requirements
- R1: Bank b, register index r, is at byte address b*32 + r*4. The indices are: 0 open-drain select, 1 data, 2 direction, 3 edge polarity, 4 any-edge, 5 mask, 6 level select, 7 status. Registers 0, 2, 3, 4, 5 and 6 read back the last value written, and the read data appears one cycle after the address.
- R2: In a bank, register bits at or above the bank's width read as 0 and ignore writes, and those pins never set status or drive. A width-0 bank reads 0 in every register.
- R3: For a pin whose direction bit is 1 (input), a read of the data register returns the synchronized pin level. For a pin whose direction bit is 0 (output), it returns the stored output value.
- R4: The pin drive rules are:
  - Direction 0 with open-drain 0: the pin is driven (pin_oe=1) with pin_out equal to the data bit.
  - Direction 0 with open-drain 1: a data value of 1 releases the pin (pin_oe=0), and a data value of 0 drives it low.
  - Direction 1: the pin is released.
  - pin_out is never 1 while pin_oe is 0.
- R5: With level select 0 and any-edge 0, edge polarity 1 sets status on a rising synchronized edge and 0 on a falling one; the opposite edge leaves status unchanged.
- R6: With level select 0 and any-edge 1, both edges set status whatever the polarity bit.
- R7: With level select 1, status is set on every cycle that the pin equals the polarity bit (1 high, 0 low). A clear written while the level is still active leaves the bit set.
- R8: Writing status clears exactly the bits written as 1; bits written as 0 are kept.
- R9: Status bits latch while masked and do not raise irq_out. Setting the mask bit later raises irq_out from the latched bit.
- R10: irq_out is 1 one cycle after any bank has a bit set in both status and mask, and wake_out always equals irq_out.
- R11: After synchronous reset, every register reads 0 except direction, which reads all ones within the bank width. irq_out, wake_out and every pin_oe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | NUM_BANKS*32 | Asynchronous pin levels, 32 per bank slot |
| pin_out | output | NUM_BANKS*32 | Output value per pin |
| pin_oe | output | NUM_BANKS*32 | Output enable per pin |
| irq_out | output | 1 | Combined interrupt for all banks |
| wake_out | output | 1 | Wake request from the masked status |

## Verification
The bench targets three trigger corner cases:
- The wrong-edge case: a pin set for falling edge is raised. A detector with the polarity inverted would latch status here.
- The any-edge case: both transitions must set the bit. A detector that ignored the any-edge bit would miss one of them.
- The level case: a clear is written while the level is still present, and the bit must stay set. A design where the clear beats the set would drop the bit.

It also checks the width boundary. Bits above an 8-pin bank and an empty middle bank must read zero, and a toggling pin above a bank's width must not latch.

The interrupt path is checked by latching status while masked, confirming that irq_out stays low, and then unmasking. Finally, pending bits in a bank other than the first must also raise the shared output.

// File: rtl/gpio_mb_pkg.sv
package gpio_mb_pkg;
  localparam int PINS_PER_BANK = 32;
  localparam int BANK_BYTES    = 32;
  localparam int WIDTH_FIELD_W = 6;

  typedef enum logic [2:0] {
    RI_ODRAIN = 3'd0,
    RI_DATA   = 3'd1,
    RI_DIR    = 3'd2,
    RI_EPOL   = 3'd3,
    RI_EANY   = 3'd4,
    RI_MASK   = 3'd5,
    RI_LSENSE = 3'd6,
    RI_STAT   = 3'd7
  } reg_idx_e;

  function automatic logic [31:0] width_mask(input int unsigned w);
    if (w >= 32) return 32'hFFFF_FFFF;
    return (32'd1 << w) - 32'd1;
  endfunction
endpackage

// File: rtl/gpio_mb_sync.sv
module gpio_mb_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_mb_bank.sv
module gpio_mb_bank
  import gpio_mb_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [2:0]  wr_idx,
  input  logic [31:0] wdata,
  input  logic [2:0]  rd_idx,
  input  logic [31:0] pin_s,
  output logic [31:0] rd_word,
  output logic [31:0] pin_out,
  output logic [31:0] pin_oe,
  output logic        pend_any
);
  localparam logic [31:0] VMASK = width_mask(WIDTH);

  generate
    if (WIDTH == 0) begin : g_empty
      logic unused_bank;
      assign unused_bank = ^{clk, rst, wr_en, wr_idx, wdata, rd_idx, pin_s};
      assign rd_word  = '0;
      assign pin_out  = '0;
      assign pin_oe   = '0;
      assign pend_any = 1'b0;
    end else begin : g_full
      logic [31:0] odrain, data, dir, epol, eany, mask, lsense, stat, prev;
      logic [31:0] rise, fall, edge_hit, lvl_hit, trig, clr;

      always_comb begin
        rise     = pin_s & ~prev;
        fall     = ~pin_s & prev;
        edge_hit = (eany & (rise | fall)) |
                   (~eany & ((epol & rise) | (~epol & fall)));
        lvl_hit  = (epol & pin_s) | (~epol & ~pin_s);
        trig     = ((lsense & lvl_hit) | (~lsense & edge_hit)) & VMASK;
        clr      = (wr_en && wr_idx == RI_STAT) ? wdata : '0;
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          odrain <= '0;
          data   <= '0;
          dir    <= VMASK;
          epol   <= '0;
          eany   <= '0;
          mask   <= '0;
          lsense <= '0;
          stat   <= '0;
          prev   <= '0;
        end else begin
          prev <= pin_s & VMASK;
          stat <= ((stat & ~clr) | trig) & VMASK;
          if (wr_en) begin
            case (wr_idx)
              RI_ODRAIN: odrain <= wdata & VMASK;
              RI_DATA:   data   <= wdata & VMASK;
              RI_DIR:    dir    <= wdata & VMASK;
              RI_EPOL:   epol   <= wdata & VMASK;
              RI_EANY:   eany   <= wdata & VMASK;
              RI_MASK:   mask   <= wdata & VMASK;
              RI_LSENSE: lsense <= wdata & VMASK;
              default:   ;
            endcase
          end
        end
      end

      always_comb begin
        case (rd_idx)
          RI_ODRAIN: rd_word = odrain;
          RI_DATA:   rd_word = ((dir & pin_s) | (~dir & data)) & VMASK;
          RI_DIR:    rd_word = dir;
          RI_EPOL:   rd_word = epol;
          RI_EANY:   rd_word = eany;
          RI_MASK:   rd_word = mask;
          RI_LSENSE: rd_word = lsense;
          default:   rd_word = stat;
        endcase
      end

      assign pin_oe   = ~dir & (~odrain | ~data) & VMASK;
      assign pin_out  = ~dir & ~odrain & data & VMASK;
      assign pend_any = |(stat & mask);
    end
  endgenerate
endmodule

// File: rtl/gpio_mb_top.sv
module gpio_mb_top
  import gpio_mb_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter logic [NUM_BANKS*6-1:0] BANK_WIDTHS = {6'd16, 6'd0, 6'd8},
  parameter int ADDR_W = $clog2(NUM_BANKS * 32)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_we,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic [NUM_BANKS*32-1:0] pin_in,
  output logic [NUM_BANKS*32-1:0] pin_out,
  output logic [NUM_BANKS*32-1:0] pin_oe,
  output logic                    irq_out,
  output logic                    wake_out
);
  localparam int NPINS  = NUM_BANKS * PINS_PER_BANK;
  localparam int BSEL_W = (ADDR_W > 5) ? ADDR_W - 5 : 1;

  logic [BSEL_W+4:0] addr_x;
  logic [BSEL_W-1:0] bank_sel;
  logic [2:0]        reg_sel;
  logic              unused_addr_lsb;
  logic [NPINS-1:0]  pin_s;
  logic [31:0]       bank_rd [NUM_BANKS];
  logic [NUM_BANKS-1:0] pend_vec;
  logic [31:0]       rdata_n;

  assign addr_x          = (BSEL_W + 5)'(bus_addr);
  assign bank_sel        = addr_x[BSEL_W+4:5];
  assign reg_sel         = addr_x[4:2];
  assign unused_addr_lsb = ^addr_x[1:0];

  gpio_mb_sync #(.W(NPINS), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_s)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int RAW = int'(BANK_WIDTHS[b*6 +: 6]);
    localparam int BW  = (RAW > 32) ? 32 : RAW;
    logic wr_here;
    assign wr_here = bus_we && (bank_sel == BSEL_W'(b));
    gpio_mb_bank #(.WIDTH(BW)) u_bank (
      .clk(clk), .rst(rst),
      .wr_en(wr_here), .wr_idx(reg_sel), .wdata(bus_wdata),
      .rd_idx(reg_sel), .pin_s(pin_s[b*32 +: 32]),
      .rd_word(bank_rd[b]),
      .pin_out(pin_out[b*32 +: 32]), .pin_oe(pin_oe[b*32 +: 32]),
      .pend_any(pend_vec[b])
    );
  end

  always_comb begin
    rdata_n = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_sel == BSEL_W'(b)) rdata_n = bank_rd[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
      wake_out  <= 1'b0;
    end else begin
      bus_rdata <= rdata_n;
      irq_out   <= |pend_vec;
      wake_out  <= |pend_vec;
    end
  end
endmodule

// File: rtl/gpio_mb_chk.sv
module gpio_mb_chk
  import gpio_mb_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter logic [NUM_BANKS*6-1:0] BANK_WIDTHS = {6'd16, 6'd0, 6'd8}
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NUM_BANKS*32-1:0] pin_out,
  input logic [NUM_BANKS*32-1:0] pin_oe,
  input logic                    irq_out,
  input logic                    wake_out,
  input logic [NUM_BANKS-1:0]    pend_vec
);
  logic [NUM_BANKS*32-1:0] valid;

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++)
      valid[b*32 +: 32] = width_mask(int'(BANK_WIDTHS[b*6 +: 6]));
  end

  assert_irq_tracks_R10: assert property (@(posedge clk) disable iff (rst)
    irq_out == $past(|pend_vec));

  assert_wake_match_R10: assert property (@(posedge clk) disable iff (rst)
    wake_out == irq_out);

  assert_no_high_released_R4: assert property (@(posedge clk) disable iff (rst)
    (pin_out & ~pin_oe) == '0);

  assert_outside_width_R2: assert property (@(posedge clk) disable iff (rst)
    ((pin_oe | pin_out) & ~valid) == '0);
endmodule

bind gpio_mb_top gpio_mb_chk #(.NUM_BANKS(NUM_BANKS), .BANK_WIDTHS(BANK_WIDTHS)) u_chk (
  .clk(clk), .rst(rst), .pin_out(pin_out), .pin_oe(pin_oe),
  .irq_out(irq_out), .wake_out(wake_out), .pend_vec(pend_vec)
);

// File: tb/tb_gpio_mb_top.sv
module tb_gpio_mb_top;
  localparam int NB = 3;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NB*32-1:0] pin_in = '0;
  logic [NB*32-1:0] pin_out, pin_oe;
  logic          irq_out, wake_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  gpio_mb_top #(.NUM_BANKS(NB), .BANK_WIDTHS({6'd16, 6'd0, 6'd8}), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out), .wake_out(wake_out)
  );

  // {we, addr[6:0], data}: data is write value when we=1, expected read value when we=0
  localparam logic [39:0] VEC [16] = '{
    {1'b1, 7'h14, 32'hFFFF_FFFF}, {1'b0, 7'h14, 32'h0000_00FF},
    {1'b1, 7'h0C, 32'h0000_00A5}, {1'b0, 7'h0C, 32'h0000_00A5},
    {1'b1, 7'h10, 32'h0000_003C}, {1'b0, 7'h10, 32'h0000_003C},
    {1'b1, 7'h18, 32'h0000_000F}, {1'b0, 7'h18, 32'h0000_000F},
    {1'b1, 7'h00, 32'h0000_0011}, {1'b0, 7'h00, 32'h0000_0011},
    {1'b1, 7'h48, 32'h1234_5678}, {1'b0, 7'h48, 32'h0000_5678},
    {1'b1, 7'h34, 32'hFFFF_FFFF}, {1'b0, 7'h34, 32'h0000_0000},
    {1'b1, 7'h5C, 32'hFFFF_FFFF}, {1'b0, 7'h5C, 32'h0000_0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    wt(5);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 irq after reset", {31'd0, irq_out}, 32'd0);
    check("R11 oe after reset", pin_oe[31:0] | pin_oe[95:64], 32'd0);
    rd(7'h08, r); check("R11 bank0 dir reset", r, 32'h0000_00FF);
    rd(7'h14, r); check("R11 bank0 mask reset", r, 32'h0);

    // R1 R2 table walk
    for (int i = 0; i < 16; i++) begin
      if (VEC[i][39]) wr(VEC[i][38:32], VEC[i][31:0]);
      else begin
        rd(VEC[i][38:32], r);
        check($sformatf("R1 R2 table[%0d]", i), r, VEC[i][31:0]);
      end
    end

    // clear leftover config
    wr(7'h18, 0); wr(7'h10, 0); wr(7'h0C, 0); wr(7'h14, 0); wr(7'h00, 0);
    wr(7'h48, 32'hFFFF);

    // R4 drive modes on bank0 pins 0..3
    wr(7'h00, 32'h0A); wr(7'h04, 32'h03); wr(7'h08, 32'h00);
    @(negedge clk);
    check("R4 oe pattern", {28'd0, pin_oe[3:0]}, 32'hD);
    check("R4 out pattern", {28'd0, pin_out[3:0]}, 32'h1);
    rd(7'h04, r); check("R3 data readback outputs", r, 32'h03);
    wr(7'h08, 32'hFF); wr(7'h00, 0); wr(7'h04, 0);
    @(negedge clk);
    check("R4 released inputs", {28'd0, pin_oe[3:0]}, 32'h0);

    // R3 input read, R2 bits above width
    pin_in[31:0] = 32'hFFFF_FF5A;
    wt(4);
    rd(7'h04, r); check("R3 R2 data input read", r, 32'h5A);

    // prepare edge tests: pin0 rising, others falling
    wr(7'h0C, 32'h01);
    pin_in[31:0] = 32'h0;
    wt(5);
    wr(7'h1C, 32'hFF);
    rd(7'h1C, r); check("R8 status cleared", r, 32'h0);

    // R5 rising
    pin_in[0] = 1'b1; wt(5);
    rd(7'h1C, r); check("R5 rising latched", r, 32'h01);
    pin_in[0] = 1'b0; wt(5);
    wr(7'h1C, 32'h01);
    rd(7'h1C, r); check("R5 falling ignored on rising pin", r, 32'h0);
    // R5 falling
    pin_in[1] = 1'b1; wt(5);
    rd(7'h1C, r); check("R5 rise ignored on falling pin", r, 32'h0);
    pin_in[1] = 1'b0; wt(5);
    rd(7'h1C, r); check("R5 falling latched", r, 32'h02);
    // R8
    wr(7'h1C, 32'h0);
    rd(7'h1C, r); check("R8 zero write keeps", r, 32'h02);
    wr(7'h1C, 32'h02);
    rd(7'h1C, r); check("R8 one write clears", r, 32'h0);

    // R6 both edges on pin2
    wr(7'h10, 32'h04);
    pin_in[2] = 1'b1; wt(5);
    rd(7'h1C, r); check("R6 rise on any-edge", r, 32'h04);
    wr(7'h1C, 32'h04);
    pin_in[2] = 1'b0; wt(5);
    rd(7'h1C, r); check("R6 fall on any-edge", r, 32'h04);

    // R9 masked latch then unmask
    wt(2);
    check("R9 masked no irq", {31'd0, irq_out}, 32'd0);
    wr(7'h14, 32'h04);
    wt(2);
    check("R9 irq on unmask", {31'd0, irq_out}, 32'd1);
    check("R10 wake follows", {31'd0, wake_out}, 32'd1);
    wr(7'h1C, 32'h04);
    wt(2);
    check("R10 irq drops after clear", {31'd0, irq_out}, 32'd0);
    wr(7'h14, 32'h0);

    // R7 level high on pin3
    wr(7'h0C, 32'h09); wr(7'h18, 32'h08);
    pin_in[3] = 1'b1; wt(5);
    wr(7'h1C, 32'h08);
    rd(7'h1C, r); check("R7 level high survives clear", r, 32'h08);
    pin_in[3] = 1'b0; wt(5);
    wr(7'h1C, 32'h08);
    rd(7'h1C, r); check("R7 level high cleared once idle", r, 32'h0);
    // R7 level low on pin4 (pin low now)
    wr(7'h18, 32'h18);
    wt(2);
    rd(7'h1C, r); check("R7 level low active", r, 32'h10);
    pin_in[4] = 1'b1; wt(5);
    wr(7'h1C, 32'h10);
    rd(7'h1C, r); check("R7 level low cleared", r, 32'h0);
    wr(7'h18, 32'h0);

    // R2 pin above bank2 width does not latch
    wr(7'h50, 32'hFFFF_FFFF);
    rd(7'h50, r); check("R2 bank2 any-edge width", r, 32'h0000_FFFF);
    pin_in[84] = 1'b1; wt(5); pin_in[84] = 1'b0; wt(5);
    rd(7'h5C, r); check("R2 pin beyond width no status", r, 32'h0);

    // R10 second bank raises shared irq
    wr(7'h54, 32'h20);
    pin_in[69] = 1'b1; wt(6);
    check("R10 bank2 irq", {31'd0, irq_out}, 32'd1);
    rd(7'h5C, r); check("R10 bank2 status", r, 32'h20);
    wr(7'h5C, 32'h20);
    wt(2);
    check("R10 bank2 irq cleared", {31'd0, irq_out}, 32'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule